// File: doc/BRIEF.md
# UART Register Bank

This block is the bus-facing register front end of a simple serial port. A host reaches it through a single-cycle register bus with one word-wide data register, one control register and one clock-divider register. The data register is both the byte path and the status view: its low byte carries the outgoing byte on a write and the captured incoming byte on a read. Two flag bits above the byte show whether a received byte is waiting and whether the transmitter can take a byte.

Bytes leave through a valid/ready transmit stream and arrive through a valid/ready receive stream. The bit-level shifter and the baud generator sit outside the block. The block only holds the interface-mode field, the two ready-override bits and the divider scale and step values, and drives them out as registered outputs.

A receive byte that arrives while the previous one is still unacknowledged is dropped. The drop is recorded in a sticky overrun bit.

Top module: `sio_regbank`

## Requirements
- R1: After synchronous reset every register reads zero, except data bit 9 (transmitter idle), which reads 1. The data register therefore reads 0x200.
- R2: A data-register write (offset 0x00) with bit 9 set while the transmitter is idle does three things on the following cycle: it presents bits 7:0 on `tx_data`, raises `tx_valid`, and makes data bit 9 read 0.
- R3: `tx_valid` and `tx_data` hold steady until `tx_ready` is seen. After that handshake `tx_valid` drops and data bit 9 reads 1 again.
- R4: A byte accepted on the receive stream while data bit 8 is 0 sets data bit 8 and appears in data bits 7:0.
- R5: A data-register write with bit 8 set clears data bit 8. If a new byte arrives in that same cycle, the new byte is stored, bit 8 stays set, and no overrun is recorded.
- R6: A data-register write with bits 9 and 8 both clear changes neither flag, the held receive byte, nor the transmit stream.
- R7: A byte arriving while data bit 8 is set is dropped and the held byte is kept. The drop sets control bit 12 (overrun), which stays set until a control write with bit 12 set clears it.
- R8: Control bits 3:2 hold the interface mode (1 = DTE, 2 = DCE), bit 7 the transmit-ready override and bit 8 the receive-ready override. They read back, drive `cfg_mode`, `cfg_tx_ovr` and `cfg_rx_ovr`, and all other control bits except 12 read 0.
- R9: The clock register (offset 0x08) holds scale in bits 27:16 and step in bits 15:0. It drives `div_scale` and `div_step` and reads back with bits 31:28 zero.
- R10: Offsets 0x0C and 0x10 read zero, and writes to them change no register. Decoding ignores address bits 1:0.
- R11: A read request returns its data on `bus_rdata` with `bus_rvalid` high exactly one cycle later.
- R12: A data-register write with bit 9 set while a byte is still pending leaves `tx_data` and `tx_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | BYTE_W | Transmit byte |
| tx_ready | input | 1 | Transmitter accepts byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | BYTE_W | Receive byte |
| rx_ready | output | 1 | Always ready outside reset |
| cfg_mode | output | 2 | Interface mode field |
| cfg_tx_ovr | output | 1 | Transmit-ready override |
| cfg_rx_ovr | output | 1 | Receive-ready override |
| div_scale | output | SCALE_W | Divider scale |
| div_step | output | STEP_W | Divider step |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands in the same clock edge as a new receive byte. The outcome depends on which of the two updates to the full flag wins. The bench reaches this case by driving the bus write and the receive valid at the same falling edge, so that both reach one rising edge together. It then checks the held byte and the overrun bit.

A second hard case is the overrun itself. It needs two arrivals with no acknowledge between them. The bench then reads back both the data register and the control register.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int WORD_W   = 32;
  localparam int OFS_DATA = 0;   // word index of 0x00
  localparam int OFS_CTRL = 1;   // word index of 0x04
  localparam int OFS_CLK  = 2;   // word index of 0x08
  localparam int D_RXFULL = 8;
  localparam int D_TXIDLE = 9;
  localparam int C_MODE_LO = 2;
  localparam int C_TXOVR  = 7;
  localparam int C_RXOVR  = 8;
  localparam int C_OVRUN  = 12;
  localparam int K_STEP_LO  = 0;
  localparam int K_SCALE_LO = 16;

  typedef enum logic [1:0] {
    RSEL_DATA = 2'd0,
    RSEL_CTRL = 2'd1,
    RSEL_CLK  = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output sio_pkg::rsel_e    sel
);
  import sio_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    if (idx == IDX_W'(OFS_DATA))      sel = RSEL_DATA;
    else if (idx == IDX_W'(OFS_CTRL)) sel = RSEL_CTRL;
    else if (idx == IDX_W'(OFS_CLK))  sel = RSEL_CLK;
    else                              sel = RSEL_NONE;
  end
endmodule

// File: rtl/sio_tx_path.sv
module sio_tx_path #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_idle
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_idle  <= 1'b1;
    end else if (tx_valid) begin
      if (tx_ready) begin
        tx_valid <= 1'b0;
        tx_idle  <= 1'b1;
      end
    end else if (launch && tx_idle) begin
      tx_valid <= 1'b1;
      tx_data  <= byte_in;
      tx_idle  <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_rx_path.sv
module sio_rx_path #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] held,
  output logic              full,
  output logic              ovr_hit
);
  logic arrive;
  logic room;

  assign arrive = rx_valid && rx_ready;
  assign room   = !full || ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ready <= 1'b0;
      held     <= '0;
      full     <= 1'b0;
      ovr_hit  <= 1'b0;
    end else begin
      rx_ready <= 1'b1;
      ovr_hit  <= arrive && !room;
      if (arrive && room) begin
        held <= rx_data;
        full <= 1'b1;
      end else if (ack) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs #(
  parameter int MODE_W  = 2,
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctrl_we,
  input  logic                      clk_we,
  input  logic [sio_pkg::WORD_W-1:0] wdata,
  input  logic                      ovr_set,
  output logic [MODE_W-1:0]         mode,
  output logic                      tx_ovr,
  output logic                      rx_ovr,
  output logic                      overrun,
  output logic [SCALE_W-1:0]        scale,
  output logic [STEP_W-1:0]         step
);
  import sio_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      tx_ovr  <= 1'b0;
      rx_ovr  <= 1'b0;
      overrun <= 1'b0;
      scale   <= '0;
      step    <= '0;
    end else begin
      if (ctrl_we) begin
        mode   <= wdata[C_MODE_LO +: MODE_W];
        tx_ovr <= wdata[C_TXOVR];
        rx_ovr <= wdata[C_RXOVR];
      end
      if (ovr_set)
        overrun <= 1'b1;
      else if (ctrl_we && wdata[C_OVRUN])
        overrun <= 1'b0;
      if (clk_we) begin
        scale <= wdata[K_SCALE_LO +: SCALE_W];
        step  <= wdata[K_STEP_LO +: STEP_W];
      end
    end
  end
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank #(
  parameter int ADDR_W  = 5,
  parameter int BYTE_W  = 8,
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic               tx_valid,
  output logic [BYTE_W-1:0]  tx_data,
  input  logic               tx_ready,
  input  logic               rx_valid,
  input  logic [BYTE_W-1:0]  rx_data,
  output logic               rx_ready,
  output logic [1:0]         cfg_mode,
  output logic               cfg_tx_ovr,
  output logic               cfg_rx_ovr,
  output logic [SCALE_W-1:0] div_scale,
  output logic [STEP_W-1:0]  div_step
);
  import sio_pkg::*;
  localparam int MODE_W = 2;

  rsel_e             rsel;
  logic              wr_en, rd_en;
  logic              data_we, ctrl_we, clk_we;
  logic              tx_idle, rx_full, ovr_hit, overrun;
  logic [BYTE_W-1:0] rx_held;
  logic [31:0]       rd_mux;

  sio_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
    .addr (bus_addr),
    .sel  (rsel)
  );

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign data_we = wr_en && (rsel == RSEL_DATA);
  assign ctrl_we = wr_en && (rsel == RSEL_CTRL);
  assign clk_we  = wr_en && (rsel == RSEL_CLK);

  sio_tx_path #(.BYTE_W(BYTE_W)) tx_i (
    .clk      (clk),
    .rst      (rst),
    .launch   (data_we && bus_wdata[D_TXIDLE]),
    .byte_in  (bus_wdata[BYTE_W-1:0]),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_idle  (tx_idle)
  );

  sio_rx_path #(.BYTE_W(BYTE_W)) rx_i (
    .clk      (clk),
    .rst      (rst),
    .ack      (data_we && bus_wdata[D_RXFULL]),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .held     (rx_held),
    .full     (rx_full),
    .ovr_hit  (ovr_hit)
  );

  sio_cfg_regs #(.MODE_W(MODE_W), .SCALE_W(SCALE_W), .STEP_W(STEP_W)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .ctrl_we (ctrl_we),
    .clk_we  (clk_we),
    .wdata   (bus_wdata),
    .ovr_set (ovr_hit),
    .mode    (cfg_mode),
    .tx_ovr  (cfg_tx_ovr),
    .rx_ovr  (cfg_rx_ovr),
    .overrun (overrun),
    .scale   (div_scale),
    .step    (div_step)
  );

  always_comb begin
    rd_mux = '0;
    unique case (rsel)
      RSEL_DATA: begin
        rd_mux[BYTE_W-1:0] = rx_held;
        rd_mux[D_RXFULL]   = rx_full;
        rd_mux[D_TXIDLE]   = tx_idle;
      end
      RSEL_CTRL: begin
        rd_mux[C_MODE_LO +: MODE_W] = cfg_mode;
        rd_mux[C_TXOVR]             = cfg_tx_ovr;
        rd_mux[C_RXOVR]             = cfg_rx_ovr;
        rd_mux[C_OVRUN]             = overrun;
      end
      RSEL_CLK: begin
        rd_mux[K_SCALE_LO +: SCALE_W] = div_scale;
        rd_mux[K_STEP_LO +: STEP_W]   = div_step;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      bus_rdata  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk #(
  parameter int ADDR_W  = 5,
  parameter int BYTE_W  = 8,
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic               tx_valid,
  input logic [BYTE_W-1:0]  tx_data,
  input logic               tx_ready,
  input logic [1:0]         cfg_mode,
  input logic [SCALE_W-1:0] div_scale,
  input logic [STEP_W-1:0]  div_step
);
  localparam int IDX_W = ADDR_W - 2;

  logic rd_req, clk_wr, ctl_wr, unm_rd;
  assign rd_req = bus_sel && !bus_wr;
  assign clk_wr = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(2));
  assign ctl_wr = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == IDX_W'(1));
  assign unm_rd = rd_req && (bus_addr[ADDR_W-1:2] > IDX_W'(2));

  // R3: pending transmit byte held until taken
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R3: handshake retires the byte
  p_tx_done_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_valid);

  // R11: read data one cycle after request
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);

  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);

  // R10: unmapped words read zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    unm_rd |=> (bus_rdata == 32'h0));

  // R9: divider outputs follow a clock-register write
  p_div_r9: assert property (@(posedge clk) disable iff (rst)
    clk_wr |=> (div_scale == $past(bus_wdata[16 +: SCALE_W]) &&
                div_step  == $past(bus_wdata[STEP_W-1:0])));

  // R8: mode output follows a control write
  p_mode_r8: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (cfg_mode == $past(bus_wdata[3:2])));
endmodule

bind sio_regbank sio_regbank_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SCALE_W(SCALE_W), .STEP_W(STEP_W)
) chk_i (.*);

// File: tb/sio_regbank_tb_top.sv
module sio_regbank_tb_top;
  localparam int ADDR_W = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic [1:0]  cfg_mode;
  logic        cfg_tx_ovr, cfg_rx_ovr;
  logic [11:0] div_scale;
  logic [15:0] div_step;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sio_regbank dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    chk("R11 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bread(5'h00, d); chk("R1 data reset", d, 32'h200);
    bread(5'h04, d); chk("R1 ctrl reset", d, 32'h0);
    bread(5'h08, d); chk("R1 clk reset", d, 32'h0);
    chk("R1 tx_valid reset", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    bwrite(5'h00, 32'h2A5);
    chk("R2 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R2 tx_data", {24'b0, tx_data}, 32'hA5);
    bread(5'h00, d); chk("R2 bit9 busy", d, 32'h000);
    bwrite(5'h00, 32'h25A);
    chk("R12 busy write ignored", {23'b0, tx_valid, tx_data}, 32'h1A5);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R3 tx_valid drops", {31'b0, tx_valid}, 32'h0);
    bread(5'h00, d); chk("R3 bit9 idle", d, 32'h200);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    rx_push(8'h3C);
    bread(5'h00, d); chk("R4 rx capture", d, 32'h33C);
    bwrite(5'h00, 32'h0FF);
    bread(5'h00, d); chk("R6 no-effect write", d, 32'h33C);
    chk("R6 no tx launch", {31'b0, tx_valid}, 32'h0);
    bwrite(5'h00, 32'h100);
    bread(5'h00, d); chk("R5 ack clears", d, 32'h23C);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    rx_push(8'h11);
    rx_push(8'h22);
    bread(5'h00, d); chk("R7 held kept", d, 32'h311);
    bread(5'h04, d); chk("R7 overrun set", d, 32'h1000);
    bwrite(5'h00, 32'h100);
    bread(5'h04, d); chk("R7 overrun sticky", d, 32'h1000);
    bwrite(5'h04, 32'h1000);
    bread(5'h04, d); chk("R7 overrun cleared", d, 32'h0);
  endtask

  task automatic t_ack_arrive();
    logic [31:0] d;
    rx_push(8'h44);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h100;
    rx_valid = 1'b1; rx_data = 8'h55;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
    bread(5'h00, d); chk("R5 ack with arrival", d, 32'h355);
    bread(5'h04, d); chk("R5 no overrun", d, 32'h0);
    bwrite(5'h00, 32'h100);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bwrite(5'h04, 32'hFFFF_EFFF);
    bread(5'h04, d); chk("R8 ctrl readback", d, 32'h18C);
    chk("R8 ctrl outputs", {28'b0, cfg_mode, cfg_tx_ovr, cfg_rx_ovr}, 32'hF);
    bwrite(5'h04, 32'h8);
    bread(5'h04, d); chk("R8 DCE mode", d, 32'h8);
    chk("R8 mode out", {30'b0, cfg_mode}, 32'h2);
  endtask

  task automatic t_clk();
    logic [31:0] d;
    bwrite(5'h08, 32'hFFFF_FFFF);
    bread(5'h08, d); chk("R9 clk mask", d, 32'h0FFF_FFFF);
    bwrite(5'h0B, 32'h0123_4567);
    bread(5'h08, d); chk("R9 clk readback", d, 32'h0123_4567);
    chk("R9 scale out", {20'b0, div_scale}, 32'h123);
    chk("R9 step out", {16'b0, div_step}, 32'h4567);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bwrite(5'h0C, 32'hFFFF_FFFF);
    bwrite(5'h10, 32'hFFFF_FFFF);
    bread(5'h0C, d); chk("R10 0x0C reads zero", d, 32'h0);
    bread(5'h10, d); chk("R10 0x10 reads zero", d, 32'h0);
    bread(5'h08, d); chk("R10 clk untouched", d, 32'h0123_4567);
    bread(5'h04, d); chk("R10 ctrl untouched", d, 32'h8);
    bread(5'h00, d); chk("R10 data untouched", d, 32'h255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rx_ready low in reset", {31'b0, rx_ready}, 32'h0);
    @(negedge clk);
    chk("R4 rx_ready", {31'b0, rx_ready}, 32'h1);
    t_reset();
    t_tx();
    t_rx();
    t_overrun();
    t_ack_arrive();
    t_ctrl();
    t_clk();
    t_unmapped();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule